// File: doc/BRIEF.md
# Dual-Channel Signalling Tone Synthesiser

This block synthesises the digital audio used for ringing, call-progress tones and dual-tone keypad signalling. Two phase-accumulator oscillators run in parallel. Each has its own 8-bit frequency word and 2-bit step-size select. One shared control picks a sine or a square waveform for both. The two channel levels are added, and the sum goes through a programmable attenuator with 3 dB steps before it is registered as a signed 16-bit sample.

The oscillators advance once per sample strobe, nominally 8 kHz. One phase LSB is therefore 8000/2048 Hz, about 3.9 Hz. The step-size select multiplies the frequency word by 1, 2 or 4, which gives steps of about 3.9, 7.8 or 15.6 Hz and top frequencies near 1 kHz, 2 kHz or 4 kHz. A single tone uses one channel with the other word at zero, and a dual tone uses both channels. Deasserting the enable returns both oscillators to zero phase and mutes the output.

Top module: `tonegen_top`

## Requirements
- R1: While `rst` is high, and at the first falling clock edge after it, `sample_out` is 0 and `sample_vld` is 0.
- R2: `sample_vld` is high for exactly the one cycle after each clock edge at which `smp_stb` was high. `sample_out` changes only on such edges.
- R3: Each channel has an 11-bit phase that wraps modulo 2048. At every strobe edge with `gen_en` high, the phase grows by the frequency word shifted left by 0, 1 or 2 for range codes 0, 1 and 2. Range code 3 behaves like code 2. The sample registered at a strobe edge uses the phase held before that edge's increment, so the first sample after enabling uses phase 0.
- R4: With `wave_sq` = 0, a channel's level is 16383·sin(2π·(P+0.5)/256), within one LSB. P is the top 8 bits of its phase.
- R5: With `wave_sq` = 1, a channel's level is +16383 when its phase MSB is 0 and −16383 when it is 1.
- R6: The value before attenuation is the sum of both channel levels.
- R7: Attenuation code k (0 to 9) scales the sum by 10^(−3k/20) in Q15 fixed point, with rounding and saturation to 16 bits. The result is within 2 LSB of the exact product. Codes 10 to 15 act as code 9.
- R8: A frequency word of 0 makes that channel's level 0, and its phase does not advance.
- R9: When `gen_en` is low at a strobe edge, the registered sample is 0 and `sample_vld` still pulses. While `gen_en` is low, both phases are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle sample strobe (nominally 8 kHz) |
| gen_en | input | 1 | Generator enable; low clears phases and mutes |
| fword_a | input | 8 | Frequency word, channel A |
| range_a | input | 2 | Step-size select, channel A (0: ×1, 1: ×2, 2/3: ×4) |
| fword_b | input | 8 | Frequency word, channel B |
| range_b | input | 2 | Step-size select, channel B |
| wave_sq | input | 1 | Waveform: 0 sine, 1 square |
| atten | input | 4 | Attenuation code, 3 dB per step, 9 maximum |
| sample_out | output | 16 | Signed output sample |
| sample_vld | output | 1 | High for one cycle when a new sample is registered |

## Verification
The phase registers are internal, so a wrong phase shows up only in the next sample. Any error in the phase step or its wrap is visible at the first valid pulse after the bad increment and keeps growing with every later strobe. A defective sine-table entry or quadrant fold appears only when the phase reaches that address. For this reason the sweep combines every range code with both small and near-maximum frequency words, so the phase covers every quadrant. A wrong gain constant or rounding offset is visible at once for its attenuation code, provided the sum is not zero.

// File: rtl/tg_pkg.sv
package tg_pkg;

    localparam int PHASE_W    = 11;
    localparam int FW_W       = 8;
    localparam int LUT_AW     = 6;
    localparam int LEVEL_W    = 15;
    localparam int FULL_SCALE = 16383;
    localparam int SUM_W      = LEVEL_W + 1;
    localparam int ATT_W      = 4;
    localparam int ATT_MAX    = 9;
    localparam int GAIN_W     = 17;
    localparam int GAIN_FRAC  = 15;
    localparam int OUT_W      = 16;

    typedef enum logic {
        WAVE_SINE   = 1'b0,
        WAVE_SQUARE = 1'b1
    } wave_e;

    typedef enum logic [1:0] {
        RNG_FINE   = 2'd0,
        RNG_MID    = 2'd1,
        RNG_COARSE = 2'd2,
        RNG_ALT    = 2'd3
    } range_e;

    typedef struct packed {
        logic [FW_W-1:0] word;
        range_e          rng;
    } chan_cfg_t;

    // left shift applied to the frequency word for a given range
    function automatic int range_shift(range_e r);
        case (r)
            RNG_FINE: return 0;
            RNG_MID:  return 1;
            default:  return 2;
        endcase
    endfunction

    // magnitude of one quarter-wave entry, sampled at half-step offsets
    function automatic logic [LEVEL_W-2:0] quarter_sine(int idx);
        real angle;
        real mag;
        angle = 2.0 * 3.14159265358979 * (real'(idx) + 0.5) / real'(4 << LUT_AW);
        mag   = real'(FULL_SCALE) * $sin(angle);
        return (LEVEL_W-1)'($rtoi(mag + 0.5));
    endfunction

    // Q1.15 gain for 3 dB per code, clamped at ATT_MAX
    function automatic logic signed [GAIN_W-1:0] att_gain(logic [ATT_W-1:0] code);
        logic [ATT_W-1:0] k;
        k = (int'(code) > ATT_MAX) ? ATT_W'(ATT_MAX) : code;
        case (k)
            4'd0:    return 17'sd32768;
            4'd1:    return 17'sd23198;
            4'd2:    return 17'sd16423;
            4'd3:    return 17'sd11627;
            4'd4:    return 17'sd8231;
            4'd5:    return 17'sd5827;
            4'd6:    return 17'sd4125;
            4'd7:    return 17'sd2920;
            4'd8:    return 17'sd2068;
            default: return 17'sd1464;
        endcase
    endfunction

endpackage

// File: rtl/tg_chan.sv
module tg_chan #(
    parameter int PW = tg_pkg::PHASE_W,
    parameter int AW = tg_pkg::LUT_AW,
    parameter int LW = tg_pkg::LEVEL_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stb,
    input  logic                 en,
    input  tg_pkg::chan_cfg_t    cfg,
    input  tg_pkg::wave_e        wave,
    output logic signed [LW-1:0] level
);
    localparam int ENTRIES = 1 << AW;
    localparam int MAG_W   = LW - 1;
    localparam int QW      = AW + 2;
    localparam logic signed [LW-1:0] POS_FS = LW'(tg_pkg::FULL_SCALE);

    logic [PW-1:0]    acc;
    logic [PW-1:0]    inc;
    logic [QW-1:0]    ph;
    logic [AW-1:0]    addr;
    logic [MAG_W-1:0] mag;
    logic [MAG_W-1:0] lut [ENTRIES];

    always_comb inc = PW'(cfg.word) << tg_pkg::range_shift(cfg.rng);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            acc <= '0;
        end else if (stb) begin
            acc <= acc + inc;
        end
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_lut
        assign lut[i] = MAG_W'(tg_pkg::quarter_sine(i));
    end

    // quadrant folding: odd quadrants mirror the address, upper half negates
    assign ph   = acc[PW-1 -: QW];
    assign addr = ph[AW] ? ~ph[AW-1:0] : ph[AW-1:0];
    assign mag  = lut[addr];

    always_comb begin
        if (cfg.word == '0) begin
            level = '0;
        end else if (wave == tg_pkg::WAVE_SQUARE) begin
            level = acc[PW-1] ? -POS_FS : POS_FS;
        end else if (ph[QW-1]) begin
            level = -$signed({1'b0, mag});
        end else begin
            level = $signed({1'b0, mag});
        end
    end

endmodule

// File: rtl/tg_scale.sv
module tg_scale #(
    parameter int SW  = tg_pkg::SUM_W,
    parameter int GW  = tg_pkg::GAIN_W,
    parameter int GF  = tg_pkg::GAIN_FRAC,
    parameter int AWD = tg_pkg::ATT_W,
    parameter int OW  = tg_pkg::OUT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stb,
    input  logic                 en,
    input  logic signed [SW-1:0] mix,
    input  logic [AWD-1:0]       att,
    output logic [OW-1:0]        sample,
    output logic                 vld
);
    localparam int PRW = SW + GW;
    localparam logic signed [PRW-1:0] HALF = PRW'(1) <<< (GF - 1);
    localparam logic signed [PRW-1:0] MAXP = PRW'((2 ** (OW - 1)) - 1);
    localparam logic signed [PRW-1:0] MINN = -MAXP - PRW'(1);

    logic signed [GW-1:0]  gain;
    logic signed [PRW-1:0] prod;
    logic signed [PRW-1:0] shifted;
    logic signed [OW-1:0]  clipped;

    assign gain    = tg_pkg::att_gain(att);
    assign prod    = PRW'(mix) * PRW'(gain);
    assign shifted = (prod + HALF) >>> GF;

    always_comb begin
        if (shifted > MAXP) begin
            clipped = MAXP[OW-1:0];
        end else if (shifted < MINN) begin
            clipped = MINN[OW-1:0];
        end else begin
            clipped = shifted[OW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample <= '0;
            vld    <= 1'b0;
        end else begin
            vld <= stb;
            if (stb) begin
                sample <= en ? clipped : '0;
            end
        end
    end

endmodule

// File: rtl/tonegen_top.sv
module tonegen_top #(
    parameter int FWW = tg_pkg::FW_W,
    parameter int RW  = 2,
    parameter int AWD = tg_pkg::ATT_W,
    parameter int OW  = tg_pkg::OUT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           smp_stb,
    input  logic           gen_en,
    input  logic [FWW-1:0] fword_a,
    input  logic [RW-1:0]  range_a,
    input  logic [FWW-1:0] fword_b,
    input  logic [RW-1:0]  range_b,
    input  logic           wave_sq,
    input  logic [AWD-1:0] atten,
    output logic [OW-1:0]  sample_out,
    output logic           sample_vld
);
    localparam int NCH = 2;
    localparam int LW  = tg_pkg::LEVEL_W;
    localparam int SW  = tg_pkg::SUM_W;

    tg_pkg::chan_cfg_t    cfg [NCH];
    tg_pkg::wave_e        wave;
    logic signed [LW-1:0] lvl [NCH];
    logic signed [SW-1:0] mix;

    assign cfg[0] = '{word: fword_a, rng: tg_pkg::range_e'(range_a)};
    assign cfg[1] = '{word: fword_b, rng: tg_pkg::range_e'(range_b)};
    assign wave   = tg_pkg::wave_e'(wave_sq);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tg_chan #(
            .PW (tg_pkg::PHASE_W),
            .AW (tg_pkg::LUT_AW),
            .LW (LW)
        ) u_chan (
            .clk   (clk),
            .rst   (rst),
            .stb   (smp_stb),
            .en    (gen_en),
            .cfg   (cfg[c]),
            .wave  (wave),
            .level (lvl[c])
        );
    end

    assign mix = SW'(lvl[0]) + SW'(lvl[1]);

    tg_scale #(
        .SW  (SW),
        .GW  (tg_pkg::GAIN_W),
        .GF  (tg_pkg::GAIN_FRAC),
        .AWD (AWD),
        .OW  (OW)
    ) u_scale (
        .clk    (clk),
        .rst    (rst),
        .stb    (smp_stb),
        .en     (gen_en),
        .mix    (mix),
        .att    (atten),
        .sample (sample_out),
        .vld    (sample_vld)
    );

endmodule

// File: rtl/tg_checker.sv
module tg_checker (
    input logic        clk,
    input logic        rst,
    input logic        smp_stb,
    input logic        gen_en,
    input logic [7:0]  fword_a,
    input logic [7:0]  fword_b,
    input logic        wave_sq,
    input logic [3:0]  atten,
    input logic [15:0] sample_out,
    input logic        sample_vld
);
    p_valid_after_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        smp_stb |=> sample_vld);

    p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> !sample_vld);

    p_sample_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> $stable(sample_out));

    p_disabled_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && !gen_en) |=> (sample_out == 16'h0000));

    p_silent_words_r8: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && gen_en && fword_a == 8'd0 && fword_b == 8'd0) |=> (sample_out == 16'h0000));

    p_square_levels_r5: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && gen_en && wave_sq && atten == 4'd0 && fword_a != 8'd0 && fword_b != 8'd0)
        |=> (sample_out == 16'h7FFE || sample_out == 16'h8002 || sample_out == 16'h0000));

endmodule

bind tonegen_top tg_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_stb    (smp_stb),
    .gen_en     (gen_en),
    .fword_a    (fword_a),
    .fword_b    (fword_b),
    .wave_sq    (wave_sq),
    .atten      (atten),
    .sample_out (sample_out),
    .sample_vld (sample_vld)
);

// File: tb/sim_tonegen_top.sv
module sim_tonegen_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_stb = 1'b0;
    logic        gen_en = 1'b0;
    logic [7:0]  fword_a = '0;
    logic [1:0]  range_a = '0;
    logic [7:0]  fword_b = '0;
    logic [1:0]  range_b = '0;
    logic        wave_sq = 1'b0;
    logic [3:0]  atten = '0;
    logic [15:0] sample_out;
    logic        sample_vld;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [10:0] pa = '0;
    logic [10:0] pb = '0;

    localparam real PI = 3.14159265358979;

    always #10 clk = ~clk;

    tonegen_top u0 (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .gen_en(gen_en),
        .fword_a(fword_a), .range_a(range_a), .fword_b(fword_b), .range_b(range_b),
        .wave_sq(wave_sq), .atten(atten), .sample_out(sample_out), .sample_vld(sample_vld)
    );

    function automatic real chan_level(logic [10:0] p, logic [7:0] w, bit sq);
        if (w == 8'd0) return 0.0;
        if (sq) return p[10] ? -16383.0 : 16383.0;
        return 16383.0 * $sin(2.0 * PI * (real'(p[10:3]) + 0.5) / 256.0);
    endfunction

    function automatic int shift_of(logic [1:0] r);
        return (r == 2'd0) ? 0 : (r == 2'd1) ? 1 : 2;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // one strobe, then the sample and valid check, then one idle cycle
    task automatic strobe_and_check(string tag);
        real exp_r;
        int  kk;
        int  act;
        int  prev;
        kk = (atten > 4'd9) ? 9 : int'(atten);
        exp_r = gen_en ? (chan_level(pa, fword_a, wave_sq) + chan_level(pb, fword_b, wave_sq))
                         * (10.0 ** (-3.0 * real'(kk) / 20.0)) : 0.0;
        smp_stb = 1'b1;
        tick();
        smp_stb = 1'b0;
        act = int'($signed(sample_out));
        check(sample_vld == 1'b1, "R2 valid after strobe", int'(sample_vld), 1);
        check((real'(act) - exp_r <= 3.0) && (exp_r - real'(act) <= 3.0), tag, act, $rtoi(exp_r));
        if (gen_en) begin
            pa = pa + (11'(fword_a) << shift_of(range_a));
            pb = pb + (11'(fword_b) << shift_of(range_b));
        end else begin
            pa = '0;
            pb = '0;
        end
        prev = act;
        tick();
        check(sample_vld == 1'b0, "R2 valid one cycle", int'(sample_vld), 0);
        check(int'($signed(sample_out)) == prev, "R2 sample held", int'($signed(sample_out)), prev);
    endtask

    task automatic configure(logic [7:0] fa, logic [1:0] ra, logic [7:0] fb, logic [1:0] rb,
                             bit sq, logic [3:0] at);
        gen_en = 1'b0;
        tick();
        pa = '0;
        pb = '0;
        fword_a = fa; range_a = ra; fword_b = fb; range_b = rb;
        wave_sq = sq; atten = at;
        gen_en = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] fa_set [4];
        logic [7:0] fb_set [4];
        fa_set[0] = 8'd255; fb_set[0] = 8'd0;
        fa_set[1] = 8'd37;  fb_set[1] = 8'd201;
        fa_set[2] = 8'd0;   fb_set[2] = 8'd0;
        fa_set[3] = 8'd128; fb_set[3] = 8'd7;

        @(negedge clk);
        tick();
        // R1: reset state
        check(sample_out == 16'h0000, "R1 sample in reset", int'(sample_out), 0);
        check(sample_vld == 1'b0, "R1 valid in reset", int'(sample_vld), 0);
        rst = 1'b0;
        @(negedge clk);
        check(sample_out == 16'h0000, "R1 sample after reset", int'(sample_out), 0);
        check(sample_vld == 1'b0, "R1 valid after reset", int'(sample_vld), 0);

        // sweep: waveform x attenuation (incl. clamp codes) x range codes x word pairs
        for (int wv = 0; wv < 2; wv++) begin
            for (int at = 0; at < 16; at++) begin
                for (int rg = 0; rg < 4; rg++) begin
                    for (int fp = 0; fp < 4; fp++) begin
                        configure(fa_set[fp], 2'(rg), fb_set[fp], 2'(rg + 1), bit'(wv), 4'(at));
                        for (int s = 0; s < 12; s++) begin
                            if (fp == 2) strobe_and_check("R8 silent words");
                            else if (wv == 1) strobe_and_check("R3 R5 R6 R7 square");
                            else strobe_and_check("R3 R4 R6 R7 sine");
                        end
                    end
                end
            end
        end

        // long run so range c wraps the phase several times
        configure(8'd250, 2'd2, 8'd99, 2'd3, 1'b0, 4'd2);
        for (int s = 0; s < 40; s++) strobe_and_check("R3 R4 wrap");

        // R9: disable mutes while valid still pulses; re-enable restarts at phase 0
        gen_en = 1'b0;
        for (int s = 0; s < 3; s++) strobe_and_check("R9 disabled zero");
        gen_en = 1'b1;
        for (int s = 0; s < 6; s++) strobe_and_check("R9 restart phase zero");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule